// File: doc/BRIEF.md
# Burst Read Latency Sequencer

This block is the timing engine on the device side of a synchronous burst-read memory. A host first writes a wait-state setting through a configuration strobe, with the setting carried as a 3-bit code on address bits 14..12. Each burst-start strobe loads the start address and a length select. The block then holds its ready flag low for the programmed initial access time. After that it presents one word address per clock, with ready high.

The initial access time depends on three things: the stored code, whether the start address is odd, and whether the first word is the last word of a 64-word block. Fixed-length bursts of 8, 16 or 32 words wrap inside their aligned group, so the address pointer never leaves its 64-word block. A continuous burst counts linearly. It spends one extra not-ready clock each time it steps into a new 64-word block. A fixed burst signals its end with a one-clock done pulse. A new start strobe abandons whatever burst is in progress.

Top module: `burst_latency_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `word_addr` is 0 and `ready` and `done` are 0. The stored setting is code 5, so an even start with no boundary takes 7 cycles of initial access.
- R2: A high `cfg_we` at a clock edge stores code `cfg_addr[14:12]`. Codes 0..5 give an even start without boundary a latency of 2..7 cycles. Latency L means that `ready` first goes high after the L-th rising edge following the edge that samples `start`.
- R3: A configuration write carrying code 6 or 7 leaves the stored setting unchanged.
- R4: An odd start address (`start_addr[0]`=1) adds one cycle of latency for codes 1..5. With code 0, odd and even starts take the same 2 cycles.
- R5: A start address with `start_addr[5:0]`=3Fh adds one more cycle of latency on top of R2 and R4.
- R6: During the latency count `ready` and `done` stay 0 and `word_addr` equals the start address. `ready` rises on the first clock that data is valid, and the first word presented is the start address.
- R7: `blen` encodes 00 = continuous, 01 = 8, 10 = 16, 11 = 32 words. A fixed burst presents exactly that many ready cycles. Its address steps by one, modulo the length, inside the aligned group of that size, so it never leaves its 64-word block.
- R8: In continuous mode the address increments by one each ready clock. A step from offset 3Fh to 40h inserts one clock with `ready` low and `word_addr` already at the new word. This stall is skipped for the first such step of a burst that started at offset 3Fh.
- R9: On the clock after the last word of a fixed burst, `done` is 1 for exactly one cycle and `ready` is 0. `word_addr` holds the last word until the next start.
- R10: A `start` during any phase of a burst abandons it without a `done` pulse and restarts the latency count for the new address.
- R11: Latency is set by the code stored at the edge that samples `start`. A configuration write during a burst affects only later bursts. A reset after programming restores the 7-cycle default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address; bits 14..12 carry the wait-state code |
| start | input | 1 | Burst-start strobe |
| start_addr | input | ADDR_W | Word address of the first word of the burst |
| blen | input | 2 | Burst length select, encoding per R7 |
| word_addr | output | ADDR_W | Current word address |
| ready | output | 1 | Data valid for `word_addr` this cycle |
| done | output | 1 | One-cycle pulse after the last word of a fixed burst |

## Verification
The assertions take for granted that `blen` is only sampled with `start`, and that every latency window is measured from a single start strobe. They also assume the host does not hold `start` high across several cycles, except when a deliberate restart is intended. The stimulus raises `start` for exactly one clock per burst and drives configuration writes on separate clocks or mid-burst only. Each restart lands on a clock that the scoreboard has already aligned to the abandoned burst's partial trace.

// File: rtl/blseq_pkg.sv
// Package: shared types, constants and the latency formula for the
// burst read latency sequencer. Assumes codes above CODE_TOP are reserved.
package blseq_pkg;

    // Burst length select encoding seen on the blen port.
    typedef enum logic [1:0] {
        BL_CONT = 2'b00,
        BL_W8   = 2'b01,
        BL_W16  = 2'b10,
        BL_W32  = 2'b11
    } blen_e;

    // Sequencer phases.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_DATA  = 2'd2,
        SQ_STALL = 2'd3
    } sq_state_e;

    localparam int          CODE_W       = 3;
    localparam int          LAT_W        = 4;
    localparam logic [2:0]  CODE_DEFAULT = 3'd5;
    localparam logic [2:0]  CODE_TOP     = 3'd5;
    localparam int          LAT_BASE     = 2;

    // Total initial access cycles for a code, odd start and block-end start.
    function automatic logic [LAT_W-1:0] total_cycles(
        input logic [CODE_W-1:0] code,
        input logic              odd,
        input logic              bnd
    );
        logic [LAT_W-1:0] t;
        t = LAT_W'(code) + LAT_W'(LAT_BASE);
        if (odd && (code != '0)) t = t + LAT_W'(1);
        if (bnd)                 t = t + LAT_W'(1);
        return t;
    endfunction

    // Number of words in a fixed burst; zero for continuous.
    function automatic int burst_words(input blen_e b);
        case (b)
            BL_W8:   return 8;
            BL_W16:  return 16;
            BL_W32:  return 32;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/blseq_cfg.sv
// Module: wait-state setting register.
// Captures the 3-bit code carried on cfg_addr[CODE_LSB+2:CODE_LSB] when
// cfg_we is high; reserved codes are dropped. Reset restores the default.
// Assumes ADDR_W > CODE_LSB + 2.
module blseq_cfg
    import blseq_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int CODE_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [CODE_W-1:0] code_q
);

    logic [CODE_W-1:0] req_code;
    logic              req_ok;
    logic              unused_cfg_bits;

    // Extract the requested code from its address-bit field.
    assign req_code        = cfg_addr[CODE_LSB +: CODE_W];
    assign req_ok          = (req_code <= CODE_TOP);
    assign unused_cfg_bits = ^cfg_addr;

    // Hold the active setting; ignore reserved codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_DEFAULT;
        end else if (cfg_we && req_ok) begin
            code_q <= req_code;
        end
    end

endmodule

// File: rtl/blseq_lat.sv
// Module: initial access down-counter.
// A load computes the total latency from the code and the start address
// properties and restarts the count; hit is high in the cycle before the
// edge on which data becomes valid. Assumes total latency >= 2.
module blseq_lat
    import blseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    input  logic              odd,
    input  logic              bnd,
    output logic              hit
);

    logic [LAT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= total_cycles(code, odd, bnd);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    // Last waiting cycle: the next edge makes data valid.
    assign hit = (cnt_q == LAT_W'(1));

endmodule

// File: rtl/blseq_addr.sv
// Module: next word address generator.
// Fixed lengths wrap inside their aligned group; continuous counts
// linearly. Also flags the last word of a 2**BLK_W block.
// Assumes BLK_W >= 5 so every fixed group fits in one block.
module blseq_addr
    import blseq_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BLK_W  = 6
) (
    input  logic [ADDR_W-1:0] cur,
    input  blen_e             mode,
    output logic [ADDR_W-1:0] nxt,
    output logic              blk_end
);

    logic [ADDR_W-1:0] wrap_mask;
    logic [ADDR_W-1:0] inc;

    // Pick which low bits roll over for the selected length.
    always_comb begin
        case (mode)
            BL_W8:   wrap_mask = ADDR_W'(7);
            BL_W16:  wrap_mask = ADDR_W'(15);
            BL_W32:  wrap_mask = ADDR_W'(31);
            default: wrap_mask = '1;
        endcase
    end

    // Merge the held group bits with the incremented in-group bits.
    always_comb begin
        inc = cur + ADDR_W'(1);
        nxt = (cur & ~wrap_mask) | (inc & wrap_mask);
    end

    // Current word is the final word of its block.
    assign blk_end = &cur[BLK_W-1:0];

endmodule

// File: rtl/burst_latency_seq.sv
// Module: burst read latency sequencer (top).
// On start it latches address and length, waits the programmed initial
// access time, then presents one word per clock with ready high. Fixed
// bursts end with a done pulse; continuous bursts stall one clock per
// block crossing. A new start aborts any burst in progress.
// Assumes blen is valid whenever start is high.
module burst_latency_seq
    import blseq_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int CODE_LSB = 12,
    parameter int BLK_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        blen,
    output logic [ADDR_W-1:0] word_addr,
    output logic              ready,
    output logic              done
);

    localparam int LEFT_W = BLK_W;

    logic [CODE_W-1:0] code_q;
    logic              lat_hit;
    logic              start_odd;
    logic              start_bnd;
    blen_e             start_mode;

    sq_state_e         st_q;
    blen_e             mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic              blk_end;
    logic [LEFT_W-1:0] left_q;
    logic              ready_q;
    logic              done_q;
    logic              skip_q;
    logic              is_fixed;
    logic              last_word;

    // Start address properties that extend the initial access.
    assign start_odd  = start_addr[0];
    assign start_bnd  = &start_addr[BLK_W-1:0];
    assign start_mode = blen_e'(blen);

    blseq_cfg #(
        .ADDR_W   (ADDR_W),
        .CODE_LSB (CODE_LSB)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .code_q   (code_q)
    );

    blseq_lat u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .code  (code_q),
        .odd   (start_odd),
        .bnd   (start_bnd),
        .hit   (lat_hit)
    );

    blseq_addr #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) u_addr (
        .cur     (addr_q),
        .mode    (mode_q),
        .nxt     (addr_nxt),
        .blk_end (blk_end)
    );

    // Burst bookkeeping decodes.
    assign is_fixed  = (mode_q != BL_CONT);
    assign last_word = is_fixed && (left_q == LEFT_W'(1));

    // Phase sequencing, address stepping and flag generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            mode_q  <= BL_CONT;
            addr_q  <= '0;
            left_q  <= '0;
            ready_q <= 1'b0;
            done_q  <= 1'b0;
            skip_q  <= 1'b0;
        end else if (start) begin
            st_q    <= SQ_WAIT;
            mode_q  <= start_mode;
            addr_q  <= start_addr;
            left_q  <= LEFT_W'(burst_words(start_mode));
            ready_q <= 1'b0;
            done_q  <= 1'b0;
            skip_q  <= start_bnd;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    done_q <= 1'b0;
                end
                SQ_WAIT: begin
                    if (lat_hit) begin
                        st_q    <= SQ_DATA;
                        ready_q <= 1'b1;
                    end
                end
                SQ_DATA: begin
                    if (last_word) begin
                        st_q    <= SQ_IDLE;
                        ready_q <= 1'b0;
                        done_q  <= 1'b1;
                    end else begin
                        addr_q <= addr_nxt;
                        skip_q <= 1'b0;
                        if (is_fixed) begin
                            left_q <= left_q - LEFT_W'(1);
                        end else if (blk_end && !skip_q) begin
                            st_q    <= SQ_STALL;
                            ready_q <= 1'b0;
                        end
                    end
                end
                SQ_STALL: begin
                    st_q    <= SQ_DATA;
                    ready_q <= 1'b1;
                end
                default: begin
                    st_q    <= SQ_IDLE;
                    ready_q <= 1'b0;
                end
            endcase
        end
    end

    assign word_addr = addr_q;
    assign ready     = ready_q;
    assign done      = done_q;

endmodule

// File: rtl/blseq_chk.sv
// Module: property checker for the burst read latency sequencer.
// Watches only the top-level ports plus its own small trackers.
// Assumes start is a single-cycle strobe per burst.
module blseq_chk
    import blseq_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BLK_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        blen,
    input logic [ADDR_W-1:0] word_addr,
    input logic              ready,
    input logic              done
);

    blen_e      mode_q;
    logic [3:0] since_q;
    logic       first_q;

    // Track mode, cycles since start and whether the first word is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= BL_CONT;
            since_q <= '0;
            first_q <= 1'b0;
        end else if (start) begin
            mode_q  <= blen_e'(blen);
            since_q <= 4'd1;
            first_q <= 1'b1;
        end else begin
            if (since_q != 4'hF) since_q <= since_q + 4'd1;
            if (ready) first_q <= 1'b0;
        end
    end

    // R6: nothing valid on the clock after a start
    a_r6_quiet_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!ready && !done));

    // R2: first ready lands within the 2..9 cycle latency range
    a_r2_latency_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && first_q) |-> (since_q >= 4'd3 && since_q <= 4'd10));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows a ready word and coincides with ready low
    a_r9_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ready) && !ready));

    // R7: fixed bursts stay inside their block
    a_r7_stay_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && mode_q != BL_CONT)
        |-> (word_addr[ADDR_W-1:BLK_W] == $past(word_addr[ADDR_W-1:BLK_W])));

    // R8: continuous bursts step by one between ready words
    a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && mode_q == BL_CONT)
        |-> (word_addr == $past(word_addr) + ADDR_W'(1)));

    // R8: a continuous stall only happens on entry to a new block
    a_r8_stall_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(ready) && !$past(start) && mode_q == BL_CONT)
        |-> (word_addr[BLK_W-1:0] == '0));

endmodule

bind burst_latency_seq blseq_chk #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W)
) u_chk (.*);

// File: tb/tb_burst_latency_seq.sv
`timescale 1ns/1ps
module tb_burst_latency_seq;

    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic          start;
    logic [AW-1:0] start_addr;
    logic [1:0]    blen;
    logic [AW-1:0] word_addr;
    logic          ready;
    logic          done;

    always #2.5 clk = ~clk;

    burst_latency_seq #(.ADDR_W(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .start      (start),
        .start_addr (start_addr),
        .blen       (blen),
        .word_addr  (word_addr),
        .ready      (ready),
        .done       (done)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic          r;
        logic          d;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    // Expected latency from R2, R4, R5.
    function automatic int lat_of(input int code, input logic [AW-1:0] a);
        int l;
        l = code + 2;
        if (a[0] && code != 0) l = l + 1;
        if (a[5:0] == 6'h3F)   l = l + 1;
        return l;
    endfunction

    // Build the per-cycle expected trace of one burst and queue it.
    task automatic build(input logic [AW-1:0] a, input logic [1:0] bl,
                         input int code, input int ncont, input int keep,
                         input string ltag, output int n);
        exp_t          list[$];
        exp_t          e;
        int            lat;
        int            bw;
        logic [AW-1:0] cur;
        logic [AW-1:0] nxt;
        logic [AW-1:0] msk;
        bit            skip;
        lat = lat_of(code, a);
        for (int i = 0; i < lat; i++) begin
            e.a = a; e.r = 1'b0; e.d = 1'b0; e.tag = ltag;
            list.push_back(e);
        end
        if (bl == 2'b00) begin
            cur  = a;
            skip = (a[5:0] == 6'h3F);
            for (int i = 0; i < ncont; i++) begin
                e.a = cur; e.r = 1'b1; e.d = 1'b0; e.tag = "R8";
                list.push_back(e);
                nxt = cur + AW'(1);
                if (cur[5:0] == 6'h3F && !skip) begin
                    e.a = nxt; e.r = 1'b0; e.tag = "R8";
                    list.push_back(e);
                end
                skip = 1'b0;
                cur  = nxt;
            end
        end else begin
            bw  = 4 << bl;
            msk = AW'(bw - 1);
            for (int i = 0; i < bw; i++) begin
                e.a = (a & ~msk) | ((a + AW'(i)) & msk);
                e.r = 1'b1; e.d = 1'b0; e.tag = "R7";
                list.push_back(e);
            end
            e.r = 1'b0; e.d = 1'b1; e.tag = "R9";
            list.push_back(e);
            e.d = 1'b0;
            list.push_back(e);
        end
        if (keep > 0) begin
            while (list.size() > keep) void'(list.pop_back());
        end
        foreach (list[i]) q.push_back(list[i]);
        n = list.size();
    endtask

    // Driver: issue one start, optionally write a code mid-burst, wait out the trace.
    task automatic burst(input logic [AW-1:0] a, input logic [1:0] bl,
                         input int code, input int ncont, input int keep,
                         input int cfg_mid, input string ltag);
        int n;
        @(negedge clk);
        start = 1'b1; start_addr = a; blen = bl;
        build(a, bl, code, ncont, keep, ltag, n);
        @(negedge clk);
        start = 1'b0;
        if (cfg_mid >= 0) begin
            cfg_we = 1'b1; cfg_addr = AW'(cfg_mid) << 12;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (n - 2) @(negedge clk);
    endtask

    // Configuration write with unrelated address bits set.
    task automatic cfg(input int code);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = (AW'(code) << 12) | AW'(21'h1800A5);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // Direct check of the outputs at the current time.
    task automatic chk_now(input string tag, input logic [AW-1:0] a,
                           input logic r, input logic d);
        checks++;
        if (word_addr !== a || ready !== r || done !== d) begin
            errors++;
            $display("FAIL %s: got addr=%h ready=%b done=%b expected addr=%h ready=%b done=%b",
                     tag, word_addr, ready, done, a, r, d);
        end
    endtask

    // Monitor: pop one expected item per clock while the scoreboard holds any.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (word_addr !== e.a || ready !== e.r || done !== e.d) begin
                    errors++;
                    $display("FAIL %s: got addr=%h ready=%b done=%b expected addr=%h ready=%b done=%b",
                             e.tag, word_addr, ready, done, e.a, e.r, e.d);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got no completion, expected finish before limit");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
        start = 1'b0; start_addr = '0; blen = 2'b00;
        repeat (3) @(negedge clk);
        chk_now("R1", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_now("R1", '0, 1'b0, 1'b0);

        // R1: default setting gives 7 cycles on an even start
        burst(21'h000100, 2'b01, 5, 0, 0, -1, "R1");

        // R2/R4: code 0, odd and even starts both 2 cycles
        cfg(0);
        burst(21'h000205, 2'b01, 0, 0, 0, -1, "R4");
        burst(21'h000040, 2'b10, 0, 0, 0, -1, "R2");

        // R2/R4: code 3, odd start adds one; 16-word wrap
        cfg(3);
        burst(21'h0001B3, 2'b10, 3, 0, 0, -1, "R4");

        // R3: reserved codes leave code 3 in place
        cfg(6);
        cfg(7);
        burst(21'h0001B4, 2'b01, 3, 0, 0, -1, "R3");

        // R5: block-end start on a 32-word burst, then no-boundary compare
        cfg(5);
        burst(21'h00013F, 2'b11, 5, 0, 0, -1, "R5");
        burst(21'h00013E, 2'b11, 5, 0, 0, -1, "R5");

        // R8: continuous burst crossing a block with one stall
        cfg(1);
        burst(21'h00003C, 2'b00, 1, 10, 0, -1, "R8");
        // R10/R8: restart from continuous; start at 3Fh skips the first stall
        burst(21'h00007F, 2'b00, 1, 6, 0, -1, "R10");

        // R10: abort during the wait, then during data
        burst(21'h000300, 2'b01, 1, 0, 2, -1, "R10");
        burst(21'h000301, 2'b01, 1, 0, 0, -1, "R10");
        burst(21'h000400, 2'b10, 1, 0, 7, -1, "R10");
        burst(21'h000500, 2'b01, 1, 0, 0, -1, "R10");

        // R11: mid-burst write affects only the next burst
        burst(21'h000600, 2'b01, 1, 0, 0, 4, "R11");
        burst(21'h000610, 2'b01, 4, 0, 0, -1, "R11");

        // R11/R1: reset after programming restores the default
        cfg(0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_now("R1", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        burst(21'h000700, 2'b01, 5, 0, 0, -1, "R11");

        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule